// File: doc/BRIEF.md
# Manchester Word Encoder with Sync

This block turns one serial word into a Manchester II line signal. Each frame has three parts: a three-bit-time sync pattern, then K data bits sent most significant bit first, then one parity bit. The frame is therefore K+4 bit times long. The block runs from one send clock at twice the bit rate, so each clock cycle is one half of a bit cell. It produces a free-running shift clock from the send clock, and the data source uses that shift clock to present bits on the serial input.

Sampling enable high at a cell boundary starts a frame. The sync kind, the parity sense and the word length are captured at that same boundary. A data-request strobe asks for exactly K bits, one per bit time. Each bit is transmitted in the cell after the one in which it is captured. If enable stays high, frames follow one another with no gap. An active-low inhibit forces both line outputs high and leaves the sequencing untouched. A master reset aborts the frame in progress.

Top module: `mwe_encoder`

## Requirements
- R1: After reset the shift clock is low, the request strobe is low and both line outputs are low (idle, nothing driven).
- R2: The shift clock toggles on every send-clock cycle. It is low in the first half of each bit cell and high in the second half, so a falling edge marks a cell boundary.
- R3: A frame starts in the cell that follows a boundary at which enable is sampled high. It lasts K+4 bit cells: 3 sync cells, K data cells and 1 parity cell.
- R4: With the command setting high, the sync is 3 half-cells high followed by 3 half-cells low. With the setting low (data sync), the sync is 3 half-cells low followed by 3 half-cells high. The setting is captured when the frame starts.
- R5: The request strobe is high for exactly K cells: the third sync cell and the first K-1 data cells. The serial input is captured at the end of each strobe cell. The bit captured in a cell is sent in the next cell, most significant bit first.
- R6: Every data and parity bit is sent Manchester II coded: a 1 is high then low within its cell, and a 0 is low then high.
- R7: The parity bit makes the count of ones over data plus parity odd when the parity setting is high, and even when it is low. The setting is captured when the frame starts.
- R8: If enable is high at the boundary that ends the parity cell, the next frame's sync starts in the very next cell. If enable is low there, the outputs return to idle (both low).
- R9: While inhibit is low, both line outputs are high. Sequencing and data capture carry on unchanged, so the frame continues correctly once inhibit is released.
- R10: While inhibit is high and a frame is active, the bipolar-zero output is the complement of the bipolar-one output.
- R11: A master reset sampled high on a send-clock edge aborts the frame. It returns the block to idle with the shift clock low, ready for a new frame.
- R12: The length setting K is captured at frame start and may be 1 to 2^KW-1. A setting of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Send clock, twice the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_en | input | 1 | Start or continue frames, sampled at cell boundaries |
| sync_cmd | input | 1 | 1 selects command sync, 0 selects data sync |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| ser_in | input | 1 | Serial data, sampled at the end of each request cell |
| k_set | input | KW | Data bits per frame (0 is treated as 1) |
| inh_n | input | 1 | Active-low output inhibit |
| mreset | input | 1 | Master reset / abort, active high, synchronous |
| shift_clk | output | 1 | Bit-rate shift clock, falling edge at cell boundary |
| data_req | output | 1 | High during cells in which a data bit is requested |
| bip_one | output | 1 | Line output, true phase |
| bip_zero | output | 1 | Line output, complementary phase |

## Verification
The sweep covers every 4-bit word with each combination of sync kind and parity sense. Together these separate the two sync shapes and the two parity senses, and they expose any bit-order or bit-offset error in the data cells. Separate frames use lengths 1, 2, 7 and the maximum of 31 with alternating, all-ones and all-zeros words, which tests the count and strobe boundaries. A length setting of 0 is checked against the length-1 layout. Back-to-back frames with settings changed mid-frame show gapless chaining and capture at frame start. An inhibited cell in the middle of a frame, and an abort followed by a clean new frame, show that inhibit changes only the line and that abort fully clears the sequencing.

// File: rtl/mwe_pkg.sv
// Shared types for the Manchester word encoder.
package mwe_pkg;
    // Frame phase of the sequencer
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SYNC = 2'd1,
        PH_DATA = 2'd2,
        PH_PAR  = 2'd3
    } phase_t;

    // Number of bit cells occupied by the sync pattern
    localparam int SYNC_CELLS = 3;
endpackage

// File: rtl/mwe_timing.sv
// Frame sequencer: half-cell toggle, cell counter and phase machine.
// Assumes clk runs at twice the bit rate; half==1 marks the second half
// of a bit cell, and the edge that ends it is the cell boundary.
module mwe_timing
    import mwe_pkg::*;
#(
    parameter int KW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mreset,
    input  logic          enc_en,
    input  logic          sync_cmd,
    input  logic          par_odd,
    input  logic [KW-1:0] k_set,
    output logic          half,
    output phase_t        phase,
    output logic [KW-1:0] cnt,
    output logic          cmd_lat,
    output logic          odd_lat,
    output logic          frame_start,
    output logic          strobe
);
    localparam logic [KW-1:0] ONE       = KW'(1);
    localparam logic [KW-1:0] SYNC_LAST = KW'(SYNC_CELLS - 1);

    logic [KW-1:0] k_lat;
    logic [KW-1:0] k_eff;
    logic          last_data;

    // Clamp a zero length setting to one bit
    always_comb k_eff = (k_set == '0) ? ONE : k_set;

    // Last data cell of the current frame
    always_comb last_data = (cnt == k_lat - ONE);

    // Frame start: at a boundary while idle or finishing parity, enable high
    always_comb frame_start = half && enc_en &&
                              ((phase == PH_IDLE) || (phase == PH_PAR));

    // Request strobe: third sync cell plus all data cells except the last
    always_comb strobe = ((phase == PH_SYNC) && (cnt == SYNC_LAST)) ||
                         ((phase == PH_DATA) && !last_data);

    // Half-cell toggle and phase/counter sequencing
    always_ff @(posedge clk) begin
        if (!rst_n || mreset) begin
            half    <= 1'b0;
            phase   <= PH_IDLE;
            cnt     <= '0;
            k_lat   <= ONE;
            cmd_lat <= 1'b0;
            odd_lat <= 1'b0;
        end else begin
            half <= ~half;
            if (half) begin
                if (frame_start) begin
                    phase   <= PH_SYNC;
                    cnt     <= '0;
                    k_lat   <= k_eff;
                    cmd_lat <= sync_cmd;
                    odd_lat <= par_odd;
                end else begin
                    unique case (phase)
                        PH_IDLE: begin
                            cnt <= '0;
                        end
                        PH_SYNC: begin
                            if (cnt == SYNC_LAST) begin
                                phase <= PH_DATA;
                                cnt   <= '0;
                            end else begin
                                cnt <= cnt + ONE;
                            end
                        end
                        PH_DATA: begin
                            if (last_data) begin
                                phase <= PH_PAR;
                                cnt   <= '0;
                            end else begin
                                cnt <= cnt + ONE;
                            end
                        end
                        PH_PAR: begin
                            phase <= PH_IDLE;
                            cnt   <= '0;
                        end
                        default: phase <= PH_IDLE;
                    endcase
                end
            end
        end
    end

    // R2
    // half_toggle_chk
    half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mreset |=> (half != $past(half)));

    // R11
    // abort_idle_chk
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mreset |=> (phase == PH_IDLE) && !half);

    // R8
    // idle_entry_chk: idle is entered only after parity, unless aborted
    idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreset && phase != PH_IDLE) |=>
            (phase != PH_IDLE) || ($past(phase) == PH_PAR));

    // R3
    // phase_hold_chk: phase changes only at cell boundaries
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreset && !half) |=> $stable(phase));
endmodule

// File: rtl/mwe_shifter.sv
// Data capture and parity accumulation.
// Captures ser_in at the end of each strobe cell; the captured bit is
// held for transmission in the following cell. Parity covers all K bits.
module mwe_shifter (
    input  logic clk,
    input  logic rst_n,
    input  logic mreset,
    input  logic half,
    input  logic strobe,
    input  logic frame_start,
    input  logic odd_lat,
    input  logic ser_in,
    output logic data_bit,
    output logic par_bit
);
    logic acc;

    // Capture the requested bit and fold it into the running parity
    always_ff @(posedge clk) begin
        if (!rst_n || mreset) begin
            data_bit <= 1'b0;
            acc      <= 1'b0;
        end else if (half) begin
            if (frame_start) begin
                acc <= 1'b0;
            end else if (strobe) begin
                data_bit <= ser_in;
                acc      <= acc ^ ser_in;
            end
        end
    end

    // Parity bit: even sense is the data XOR, odd sense inverts it
    always_comb par_bit = acc ^ odd_lat;

    // R5
    // capture_hold_chk: captured bit changes only at a strobe boundary
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || mreset)
        !(half && strobe) |=> $stable(data_bit));
endmodule

// File: rtl/mwe_line.sv
// Line level generation and bipolar drive with inhibit.
// Assumes the sequencer holds phase and cnt for a full bit cell.
module mwe_line
    import mwe_pkg::*;
#(
    parameter int KW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mreset,
    input  logic          half,
    input  phase_t        phase,
    input  logic [KW-1:0] cnt,
    input  logic          cmd_lat,
    input  logic          data_bit,
    input  logic          par_bit,
    input  logic          inh_n,
    output logic          bip_one,
    output logic          bip_zero
);
    logic [2:0] sync_idx;
    logic       level;

    // Half-cell index within the sync pattern (0..5)
    always_comb sync_idx = {cnt[1:0], 1'b0} + {2'b00, half};

    // Line level for the current half cell
    always_comb begin
        unique case (phase)
            PH_SYNC: level = cmd_lat ? (sync_idx < 3'd3) : (sync_idx >= 3'd3);
            PH_DATA: level = data_bit ^ half;
            PH_PAR:  level = par_bit ^ half;
            default: level = 1'b0;
        endcase
    end

    // Bipolar drive: inhibit forces both high, idle drives neither
    always_comb begin
        if (!inh_n) begin
            bip_one  = 1'b1;
            bip_zero = 1'b1;
        end else if (phase == PH_IDLE) begin
            bip_one  = 1'b0;
            bip_zero = 1'b0;
        end else begin
            bip_one  = level;
            bip_zero = ~level;
        end
    end

    // R6
    // mid_cell_flip_chk: data and parity cells flip at mid-cell
    mid_cell_flip_chk: assert property (@(posedge clk) disable iff (!rst_n || mreset)
        (!half && (phase == PH_DATA || phase == PH_PAR)) |=>
            (level != $past(level)));

    // R4
    // sync_mid_chk: sync level flips in the middle of the second sync cell
    sync_mid_chk: assert property (@(posedge clk) disable iff (!rst_n || mreset)
        (!half && phase == PH_SYNC && cnt == KW'(1)) |=> (level != $past(level)));

    // R9
    // inhibit_high_chk
    inhibit_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inh_n |-> (bip_one && bip_zero));
endmodule

// File: rtl/mwe_encoder.sv
// Manchester word encoder top: sequencer, data capture and line drive.
// Assumes clk is the send clock at twice the bit rate; rst_n is the
// synchronous chip reset, mreset a synchronous abort.
module mwe_encoder
    import mwe_pkg::*;
#(
    parameter int KW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enc_en,
    input  logic          sync_cmd,
    input  logic          par_odd,
    input  logic          ser_in,
    input  logic [KW-1:0] k_set,
    input  logic          inh_n,
    input  logic          mreset,
    output logic          shift_clk,
    output logic          data_req,
    output logic          bip_one,
    output logic          bip_zero
);
    logic          half;
    phase_t        phase;
    logic [KW-1:0] cnt;
    logic          cmd_lat;
    logic          odd_lat;
    logic          frame_start;
    logic          strobe;
    logic          data_bit;
    logic          par_bit;

    mwe_timing #(.KW(KW)) u_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .mreset      (mreset),
        .enc_en      (enc_en),
        .sync_cmd    (sync_cmd),
        .par_odd     (par_odd),
        .k_set       (k_set),
        .half        (half),
        .phase       (phase),
        .cnt         (cnt),
        .cmd_lat     (cmd_lat),
        .odd_lat     (odd_lat),
        .frame_start (frame_start),
        .strobe      (strobe)
    );

    mwe_shifter u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .mreset      (mreset),
        .half        (half),
        .strobe      (strobe),
        .frame_start (frame_start),
        .odd_lat     (odd_lat),
        .ser_in      (ser_in),
        .data_bit    (data_bit),
        .par_bit     (par_bit)
    );

    mwe_line #(.KW(KW)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .mreset   (mreset),
        .half     (half),
        .phase    (phase),
        .cnt      (cnt),
        .cmd_lat  (cmd_lat),
        .data_bit (data_bit),
        .par_bit  (par_bit),
        .inh_n    (inh_n),
        .bip_one  (bip_one),
        .bip_zero (bip_zero)
    );

    // Shift clock: high in the second half of each cell
    always_comb shift_clk = half;
    always_comb data_req  = strobe;

    // R10
    // complement_chk
    complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_n && phase != PH_IDLE) |-> (bip_zero != bip_one));

    // R5
    // req_phase_chk: requests occur only during sync or data cells
    req_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |-> (phase == PH_SYNC || phase == PH_DATA));
endmodule

// File: tb/test_mwe_encoder.sv
`timescale 1ns/1ps
module test_mwe_encoder;
    localparam int KW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enc_en = 1'b0;
    logic          sync_cmd = 1'b0;
    logic          par_odd = 1'b0;
    logic          ser_in = 1'b0;
    logic [KW-1:0] k_set = '0;
    logic          inh_n = 1'b1;
    logic          mreset = 1'b0;
    logic          shift_clk, data_req, bip_one, bip_zero;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mwe_encoder #(.KW(KW)) i_mwe_encoder (
        .clk(clk), .rst_n(rst_n), .enc_en(enc_en), .sync_cmd(sync_cmd),
        .par_odd(par_odd), .ser_in(ser_in), .k_set(k_set), .inh_n(inh_n),
        .mreset(mreset), .shift_clk(shift_clk), .data_req(data_req),
        .bip_one(bip_one), .bip_zero(bip_zero)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Wait until a negedge where shift_clk is high (next posedge is a boundary)
    task automatic align();
        do @(negedge clk); while (shift_clk !== 1'b1);
    endtask

    // One frame; caller is at a negedge before a boundary. Settings are
    // applied here; klen is the effective length used by the model.
    task automatic frame(input int kset, input int klen, input logic [31:0] word,
                         input logic cmd, input logic odd, input logic keep,
                         input int inh_cell);
        logic par;
        par = (^(word & ((32'd1 << klen) - 1))) ^ odd;
        k_set = KW'(kset); sync_cmd = cmd; par_odd = odd; enc_en = 1'b1;
        for (int i = 0; i < 2 * (klen + 4); i++) begin
            int c, h;
            logic lvl, bitv, req;
            @(negedge clk);
            c = i / 2; h = i % 2;
            // scramble settings after start: they must have been captured (R4, R7, R12)
            if (i == 1) begin sync_cmd = ~cmd; par_odd = ~odd; k_set = KW'(kset + 3); end
            inh_n = (c == inh_cell) ? 1'b0 : 1'b1;
            req = (c >= 2 && c <= klen + 1);
            ser_in = req ? word[klen - 1 - (c - 2)] : 1'b0;
            if (c < 3)               lvl = cmd ? (i < 3) : (i >= 3);
            else if (c < klen + 3) begin bitv = word[klen - 1 - (c - 3)]; lvl = bitv ^ h[0]; end
            else                     lvl = par ^ h[0];
            if (i == 2 * (klen + 4) - 1) enc_en = keep;
            #1;
            chk("R2 shift_clk", {3'b0, shift_clk}, {3'b0, h[0]});
            chk("R5 data_req", {3'b0, data_req}, {3'b0, req});
            if (c == inh_cell)
                chk("R9 inhibit", {2'b0, bip_one, bip_zero}, 4'b0011);
            else if (c < 3)
                chk("R4 sync", {2'b0, bip_one, bip_zero}, {2'b0, lvl, ~lvl});
            else if (c < klen + 3)
                chk("R6 data", {2'b0, bip_one, bip_zero}, {2'b0, lvl, ~lvl});
            else
                chk("R7 parity R10", {2'b0, bip_one, bip_zero}, {2'b0, lvl, ~lvl});
        end
        inh_n = 1'b1;
    endtask

    // Idle check after a frame ended with enable low (R8)
    task automatic idle_check(input string req);
        @(negedge clk); #1;
        chk(req, {1'b0, data_req, bip_one, bip_zero}, 4'b0000);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 reset", {shift_clk, data_req, bip_one, bip_zero}, 4'b0000);
        rst_n = 1'b1;

        // Sweep: all 4-bit words, both syncs, both parities (R3 R4 R6 R7)
        for (int w = 0; w < 16; w++)
            for (int m = 0; m < 4; m++) begin
                align();
                frame(4, 4, 32'(w), m[0], m[1], 1'b0, -1);
                idle_check("R8 idle after frame");
            end

        // Length boundaries (R5 R12)
        align(); frame(1, 1, 32'h1, 1'b1, 1'b1, 1'b0, -1); idle_check("R3 K=1");
        align(); frame(2, 2, 32'h2, 1'b0, 1'b0, 1'b0, -1); idle_check("R3 K=2");
        align(); frame(7, 7, 32'h55, 1'b1, 1'b0, 1'b0, -1); idle_check("R3 K=7");
        align(); frame(31, 31, 32'h2AAA_AAAA, 1'b0, 1'b1, 1'b0, -1); idle_check("R3 K=31");
        align(); frame(31, 31, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0, -1); idle_check("R7 all ones");
        align(); frame(31, 31, 32'h0, 1'b0, 1'b1, 1'b0, -1); idle_check("R7 all zeros");
        // R12 zero length behaves as one
        align(); frame(0, 1, 32'h0, 1'b0, 1'b0, 1'b0, -1); idle_check("R12 K=0");

        // Back-to-back frames with no gap (R8)
        align();
        frame(5, 5, 32'h13, 1'b1, 1'b0, 1'b1, -1);
        frame(3, 3, 32'h6, 1'b0, 1'b1, 1'b1, -1);
        frame(6, 6, 32'h2D, 1'b1, 1'b1, 1'b0, -1);
        idle_check("R8 chain end");

        // Inhibit in the middle of a frame (R9)
        align(); frame(6, 6, 32'h39, 1'b1, 1'b0, 1'b0, 4); idle_check("R9 after inhibit");
        align(); frame(4, 4, 32'hA, 1'b0, 1'b1, 1'b0, 1); idle_check("R9 after inhibit sync");

        // Abort mid-frame (R11)
        align();
        k_set = KW'(8); sync_cmd = 1'b1; enc_en = 1'b1;
        repeat (9) @(negedge clk);
        enc_en = 1'b0; mreset = 1'b1;
        @(negedge clk); mreset = 1'b0; #1;
        chk("R11 abort", {shift_clk, data_req, bip_one, bip_zero}, 4'b0000);
        @(negedge clk); #1;
        chk("R11 stays idle", {shift_clk, data_req, bip_one, bip_zero}, 4'b1000);
        frame(4, 4, 32'h9, 1'b0, 1'b0, 1'b0, -1);
        idle_check("R11 fresh frame");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule